// File: doc/BRIEF.md
# Filtered Reset Controller with Cause Flags

This block gathers three reset requests into one system reset and keeps a record of what caused it. The sources are an active-low external reset pin, a power-on request that is high while the supply is not yet ready, and a digital low-supply flag from an analog comparator that sits outside the block. The pin and the low-supply flag are first brought into the clock domain with two-flop synchronizers. Each one then goes through its own qualification filter, so that short glitches never reset the chip.

The system reset output goes high at once when power-on is requested, without waiting for a clock edge. It also goes high on the clock edge after any filtered request becomes active. Once every request has gone away, the output is held high for a set number of cycles and is then released on a clock edge. Each accepted source sets a sticky flag in a 32-bit status register. Software reads that register and clears flags by writing 1s to it. Only the power-on request initializes the register, so the flags are still there after the pin or low-supply reset that set them.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_req_i` is 1, `sys_rst_o` is 1. It rises without waiting for a clock edge when `por_req_i` rises.
- R2: A pin request is accepted only after PIN_FILT_CYC+1 consecutive synchronized low samples of `pin_rst_n_i`. A low run of PIN_FILT_CYC samples or fewer is ignored: no reset and no flag.
- R3: An accepted pin request asserts `sys_rst_o` and sets status bit 1.
- R4: A low-supply request (`lv_low_i`=1) is accepted only after LV_ON_CYC (16) consecutive synchronized samples. An accepted request asserts `sys_rst_o` and sets status bit 3. Shorter pulses are ignored.
- R5: An accepted low-supply request is held until `lv_low_i` has been 0 for LV_OFF_CYC consecutive synchronized samples. A shorter good interval restarts the count.
- R6: After the last request drops, `sys_rst_o` stays 1 for exactly STRETCH_CYC cycles (STRETCH_CYC at least 1). Counted from the input edges, it falls 3+STRETCH_CYC clock edges after the pin returns high, 2+LV_OFF_CYC+STRETCH_CYC edges after `lv_low_i` returns to 0, and STRETCH_CYC edges after `por_req_i` falls.
- R7: A write to STAT_ADDR clears each flag whose data bit is 1. A 0 bit leaves its flag unchanged. Bits 2 and 31:4 always read 0, and every other address reads 0.
- R8: If a write clears a flag in the same cycle that a new event sets it, the flag ends up set.
- R9: A pin or low-supply reset does not clear any status flag.
- R10: While `por_req_i` is 1 the status register becomes 0x1 (bit 0 set, all others clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req_i | input | 1 | Power-on request, 1 while the supply is not ready |
| pin_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| lv_low_i | input | 1 | Digitized low-supply comparator output, asynchronous |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 32 | Write data, 1s clear flags |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
The assertions take two things for granted. First, `por_req_i`, which also acts as the synchronous initializer of the filters and the status register, is held high for at least one clock edge whenever it is raised. Second, the register inputs are stable around each edge. The bench therefore changes every input 1 ns after a rising edge, holds power-on for several edges, and raises it mid-cycle only to observe the immediate reset. Pulses on the asynchronous pin and low-supply inputs are whole multiples of the clock period, so the sample counts in R2, R4 and R5 can be hit exactly, one below and at the limit.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int STAT_W  = 4;
    localparam int POR_BIT = 0;
    localparam int PIN_BIT = 1;
    localparam int LV_BIT  = 3;

    typedef struct packed {
        logic lv;
        logic rsvd;
        logic pin;
        logic por;
    } cause_t;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_t;

    localparam cause_t CAUSE_POR_INIT = '{lv: 1'b0, rsvd: 1'b0, pin: 1'b0, por: 1'b1};

    function automatic cause_t cause_update(cause_t cur, cause_t clr, cause_t set);
        cause_t nxt;
        nxt      = (cur & ~clr) | set;
        nxt.rsvd = 1'b0;
        return nxt;
    endfunction

endpackage

// File: rtl/rstc_sync2.sv
module rstc_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/rstc_filter.sv
module rstc_filter
    import rstc_pkg::*;
#(
    parameter int ON_CYC  = 16,
    parameter int OFF_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_i,
    output logic active_o
);
    localparam int MAX_CYC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    req_state_t       state_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] limit;
    logic             differs;

    always_comb begin
        if (state_q == REQ_IDLE) begin
            differs = sample_i;
            limit   = CNT_W'(ON_CYC - 1);
        end else begin
            differs = !sample_i;
            limit   = CNT_W'(OFF_CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= REQ_IDLE;
            run_q   <= '0;
        end else if (!differs) begin
            run_q <= '0;
        end else if (run_q == limit) begin
            state_q <= (state_q == REQ_IDLE) ? REQ_ACTIVE : REQ_IDLE;
            run_q   <= '0;
        end else begin
            run_q <= run_q + CNT_W'(1);
        end
    end

    assign active_o = (state_q == REQ_ACTIVE);

    // R2 / R4: a request becomes active only on a sample that asks for it
    p_rise_needs_sample_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(active_o) |-> $past(sample_i));
    // R5: a request is released only on a sample that no longer asks for it
    p_fall_needs_sample_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(active_o) |-> !$past(sample_i));
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic por_i,
    input  logic req_i,
    output logic rst_o
);
    localparam int CNT_W = $clog2(STRETCH_CYC + 1);

    logic [CNT_W-1:0] hold_q;
    logic             rst_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            rst_q  <= 1'b1;
            hold_q <= CNT_W'(STRETCH_CYC);
        end else if (req_i) begin
            rst_q  <= 1'b1;
            hold_q <= CNT_W'(STRETCH_CYC);
        end else if (hold_q > CNT_W'(1)) begin
            hold_q <= hold_q - CNT_W'(1);
        end else begin
            hold_q <= '0;
            rst_q  <= 1'b0;
        end
    end

    assign rst_o = rst_q;

    // R6: a live request always leaves reset asserted on the next cycle
    p_req_holds_rst_r6: assert property (@(posedge clk) disable iff (por_i)
        req_i |=> rst_o);
    // R6: release never follows a cycle with a request
    p_release_quiet_r6: assert property (@(posedge clk) disable iff (por_i)
        $fell(rst_o) |-> !$past(req_i));
endmodule

// File: rtl/rstc_status.sv
module rstc_status
    import rstc_pkg::*;
(
    input  logic              clk,
    input  logic              por_i,
    input  logic              pin_act_i,
    input  logic              lv_act_i,
    input  logic              wr_i,
    input  logic [STAT_W-1:0] clr_bits_i,
    output cause_t            flags_o
);
    cause_t flags_q;
    cause_t set_v;
    cause_t clr_v;
    logic   pin_prev_q;
    logic   lv_prev_q;

    always_comb begin
        set_v     = '0;
        set_v.pin = pin_act_i && !pin_prev_q;
        set_v.lv  = lv_act_i && !lv_prev_q;
        clr_v     = wr_i ? cause_t'(clr_bits_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            flags_q    <= CAUSE_POR_INIT;
            pin_prev_q <= 1'b0;
            lv_prev_q  <= 1'b0;
        end else begin
            flags_q    <= cause_update(flags_q, clr_v, set_v);
            pin_prev_q <= pin_act_i;
            lv_prev_q  <= lv_act_i;
        end
    end

    assign flags_o = flags_q;

    // R8: a new pin event wins over a clear in the same cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (por_i)
        (pin_act_i && !pin_prev_q) |=> flags_o.pin);
    // R4: a new low-supply event leaves its flag set
    p_lv_flag_r4: assert property (@(posedge clk) disable iff (por_i)
        (lv_act_i && !lv_prev_q) |=> flags_o.lv);
    // R9: the pin flag only falls by a software write of 1
    p_pin_w1c_only_r9: assert property (@(posedge clk) disable iff (por_i)
        $fell(flags_o.pin) |-> $past(wr_i && clr_bits_i[PIN_BIT]));
    // R9: the low-supply flag only falls by a software write of 1
    p_lv_w1c_only_r9: assert property (@(posedge clk) disable iff (por_i)
        $fell(flags_o.lv) |-> $past(wr_i && clr_bits_i[LV_BIT]));
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rstc_pkg::*;
#(
    parameter int PIN_FILT_CYC = 9000,
    parameter int LV_ON_CYC    = 16,
    parameter int LV_OFF_CYC   = 16,
    parameter int STRETCH_CYC  = 16,
    parameter int ADDR_W       = 4,
    parameter int STAT_ADDR    = 0
) (
    input  logic              clk,
    input  logic              por_req_i,
    input  logic              pin_rst_n_i,
    input  logic              lv_low_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              sys_rst_o
);
    localparam int PIN_ON_CYC = PIN_FILT_CYC + 1;

    logic   pin_n_sync;
    logic   lv_sync;
    logic   pin_act;
    logic   lv_act;
    logic   stat_hit;
    cause_t flags;

    rstc_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst(por_req_i), .d_i(pin_rst_n_i), .q_o(pin_n_sync));

    rstc_sync2 #(.RST_VAL(1'b0)) u_lv_sync (
        .clk(clk), .rst(por_req_i), .d_i(lv_low_i), .q_o(lv_sync));

    rstc_filter #(.ON_CYC(PIN_ON_CYC), .OFF_CYC(1)) u_pin_filt (
        .clk(clk), .rst(por_req_i), .sample_i(!pin_n_sync), .active_o(pin_act));

    rstc_filter #(.ON_CYC(LV_ON_CYC), .OFF_CYC(LV_OFF_CYC)) u_lv_filt (
        .clk(clk), .rst(por_req_i), .sample_i(lv_sync), .active_o(lv_act));

    rstc_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk(clk), .por_i(por_req_i), .req_i(pin_act || lv_act), .rst_o(sys_rst_o));

    assign stat_hit = (reg_addr_i == ADDR_W'(STAT_ADDR));

    rstc_status u_status (
        .clk(clk),
        .por_i(por_req_i),
        .pin_act_i(pin_act),
        .lv_act_i(lv_act),
        .wr_i(reg_we_i && stat_hit),
        .clr_bits_i(reg_wdata_i[STAT_W-1:0]),
        .flags_o(flags)
    );

    assign reg_rdata_o = stat_hit ? {{(32-STAT_W){1'b0}}, flags} : 32'h0;

    // R7: reserved bits of the read path stay clear
    always_comb begin
        p_rsvd_zero_r7: assert (reg_rdata_o[31:STAT_W] == '0 && !reg_rdata_o[2]);
    end
endmodule

// File: tb/rst_cause_ctrl_tb.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb_top;
    localparam int PF = 20;
    localparam int LVON = 16;
    localparam int LVOFF = 16;
    localparam int ST = 8;

    logic        clk = 1'b0;
    logic        por_req = 1'b1;
    logic        pin_n = 1'b1;
    logic        lv = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        sys_rst;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rst_cause_ctrl #(
        .PIN_FILT_CYC(PF), .LV_ON_CYC(LVON), .LV_OFF_CYC(LVOFF),
        .STRETCH_CYC(ST), .ADDR_W(4), .STAT_ADDR(0)
    ) dut_i (
        .clk(clk), .por_req_i(por_req), .pin_rst_n_i(pin_n), .lv_low_i(lv),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .sys_rst_o(sys_rst)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic read_stat(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #0.5;
        v = rdata;
        addr = 4'd0;
    endtask

    task automatic write_stat(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick(1);
        we = 1'b0; addr = 4'd0; wdata = 32'h0;
    endtask

    task automatic edges_to_release(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            tick(1);
            n++;
            if (!sys_rst) break;
        end
    endtask

    task automatic watch_rst(input int n, output bit seen, output bit all_high);
        seen = 1'b0; all_high = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (sys_rst) seen = 1'b1; else all_high = 1'b0;
        end
    endtask

    task automatic t_por_start();
        logic [31:0] v;
        int n;
        tick(4);
        check(sys_rst == 1'b1, "R1 reset held during power-on", sys_rst, 1);
        read_stat(4'd0, v);
        check(v == 32'h1, "R10 status after power-on", v, 32'h1);
        por_req = 1'b0;
        edges_to_release(n);
        check(n == ST, "R6 stretch after power-on", n, ST);
    endtask

    task automatic t_pin_short();
        logic [31:0] v;
        bit seen, hi;
        pin_n = 1'b0;
        tick(PF);
        pin_n = 1'b1;
        watch_rst(40, seen, hi);
        check(!seen, "R2 short pin pulse ignored", seen, 0);
        read_stat(4'd0, v);
        check(v[1] == 1'b0, "R2 no pin flag after short pulse", v, 32'h1);
    endtask

    task automatic t_pin_accept();
        logic [31:0] v;
        bit seen, hi;
        int n;
        pin_n = 1'b0;
        tick(PF + 1);
        pin_n = 1'b1;
        watch_rst(10, seen, hi);
        check(seen, "R3 pin pulse at limit resets", seen, 1);
        tick(30);
        read_stat(4'd0, v);
        check(v == 32'h3, "R3 pin flag set, R9 kept after release", v, 32'h3);
        pin_n = 1'b0;
        tick(40);
        check(sys_rst == 1'b1, "R3 long pin low holds reset", sys_rst, 1);
        pin_n = 1'b1;
        edges_to_release(n);
        check(n == 3 + ST, "R6 release after pin", n, 3 + ST);
    endtask

    task automatic t_lv();
        logic [31:0] v;
        bit seen, hi;
        int n;
        lv = 1'b1;
        tick(LVON - 1);
        lv = 1'b0;
        watch_rst(40, seen, hi);
        check(!seen, "R4 short low-supply pulse ignored", seen, 0);
        read_stat(4'd0, v);
        check(v[3] == 1'b0, "R4 no low-supply flag after short pulse", v, 32'h3);
        lv = 1'b1;
        tick(LVON);
        lv = 1'b0;
        watch_rst(6, seen, hi);
        check(seen, "R4 low-supply pulse at limit resets", seen, 1);
        tick(30 + LVOFF);
        read_stat(4'd0, v);
        check(v == 32'hB, "R4 low-supply flag, R9 flags kept", v, 32'hB);
        lv = 1'b1;
        tick(30);
        lv = 1'b0;
        tick(LVOFF - 1);
        lv = 1'b1;
        watch_rst(30, seen, hi);
        check(hi, "R5 short good interval keeps reset", hi, 1);
        lv = 1'b0;
        edges_to_release(n);
        check(n == 2 + LVOFF + ST, "R6 release after low-supply", n, 2 + LVOFF + ST);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        write_stat(4'd0, 32'h0);
        read_stat(4'd0, v);
        check(v == 32'hB, "R7 zero write keeps flags", v, 32'hB);
        write_stat(4'd0, 32'hFFFF_FFF4);
        read_stat(4'd0, v);
        check(v == 32'hB, "R7 reserved bits write keeps flags", v, 32'hB);
        write_stat(4'd5, 32'hF);
        read_stat(4'd0, v);
        check(v == 32'hB, "R7 write to other address ignored", v, 32'hB);
        read_stat(4'd5, v);
        check(v == 32'h0, "R7 other address reads zero", v, 0);
        write_stat(4'd0, 32'h1);
        read_stat(4'd0, v);
        check(v == 32'hA, "R7 clear power-on flag", v, 32'hA);
        write_stat(4'd0, 32'h8);
        read_stat(4'd0, v);
        check(v == 32'h2, "R7 clear low-supply flag", v, 32'h2);
        write_stat(4'd0, 32'h2);
        read_stat(4'd0, v);
        check(v == 32'h0, "R7 clear pin flag", v, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        int n;
        pin_n = 1'b0;
        tick(PF + 3);
        write_stat(4'd0, 32'h2);
        read_stat(4'd0, v);
        check(v == 32'h2, "R8 set wins over same-cycle clear", v, 32'h2);
        pin_n = 1'b1;
        edges_to_release(n);
        check(n > 0 && !sys_rst, "R6 reset released after pin", sys_rst, 0);
        lv = 1'b1;
    endtask

    task automatic t_por_again();
        logic [31:0] v;
        int n;
        lv = 1'b0;
        tick(40);
        check(sys_rst == 1'b0, "R6 idle before power-on", sys_rst, 0);
        #1;
        por_req = 1'b1;
        #0.5;
        check(sys_rst == 1'b1, "R1 immediate reset on power-on", sys_rst, 1);
        tick(3);
        read_stat(4'd0, v);
        check(v == 32'h1, "R10 power-on reinitializes flags", v, 32'h1);
        por_req = 1'b0;
        edges_to_release(n);
        check(n == ST, "R6 stretch after second power-on", n, ST);
    endtask

    initial begin
        t_por_start();
        t_pin_short();
        t_pin_accept();
        t_lv();
        t_w1c();
        t_set_wins();
        t_por_again();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule